// File: doc/BRIEF.md
# DMA End-of-Process Termination Handler

This block handles the active-low, open-drain end-of-process line of a DMA transfer sequencer. The line is shared: an external agent may pull it low to stop the current transfer, and the sequencer pulls it low itself when the word count of the active channel runs out. The sequencer's state machine is visible to the block. Its states are idle, S0 to S4, S1 again for each further transfer, and idle once more at the end. The block uses these states to decide when an external request is accepted and when it takes effect.

The external line first passes through a synchroniser. The block then looks for a falling edge. A falling edge is latched only while the sequencer is active. The latched request is applied on the clock edge that leaves the next S2 state. If the sequencer goes idle before that, the request is dropped without effect. An edge seen while idle is never recorded. This covers the gaps between bursts in demand mode.

When the count rolls over, the block drives the line low for one transfer cycle. It does not mistake its own drive for an external request. Either kind of termination produces a single action pulse for the channel that was active. The action pulse clears that channel's software request, sets its terminal-count status, and sets its mask bit when auto-initialise is off. The pin is modelled as an input plus an output and an output enable. Downstream logic treats the enable as a pull to ground.

Top module: `dma_eop_ctrl`

## Requirements
- R1: After reset, `eop_oe`, `term_o`, `sreq_clr_o`, `tc_set_o` and `mask_set_o` are all zero, and no external request is pending.
- R2: A falling edge on `eop_in_n` that is seen while `st_i` is idle (code 0) is never acted on, even if the sequencer later becomes active. A falling edge is seen SYNC_STAGES+1 edges after the pin falls.
- R3: A falling edge seen while `st_i` is active (codes 1 to 5) is latched. On the edge that leaves the next S2 state (code 3), `term_o` then pulses high for one cycle.
- R4: A latched request is discarded on any edge where `st_i` is idle. After that, no action follows from it.
- R5: When `dec_i` is high, `cnt_i` is zero and `st_i` is active, the block counts this as a rollover. On the next edge `term_o` pulses and `eop_oe` goes high. `eop_oe` stays high until the edge where `st_i` is S4 (code 5). A decrement with a nonzero count has no effect.
- R6: The block's own drive of the line never sets the external request latch. The S2 state after a count rollover produces no further action.
- R7: Each action pulse raises `sreq_clr_o` and `tc_set_o` for the channel given by `act_ch_i` (bit index = channel number) and for no other channel. It raises `mask_set_o` for that channel only when its `autoinit_i` bit is 0.
- R8: A pending external request and a rollover on the same S2 edge give one `term_o` pulse of one cycle and one channel update. The pending request is consumed.
- R9: `eop_out` is always 0; the line is only ever pulled low, never driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_i | input | 3 | Sequencer state: 0 idle, 1 S0, 2 S1, 3 S2, 4 S3, 5 S4 |
| act_ch_i | input | CH_W | Channel currently being served |
| cnt_i | input | CNT_W | Current word count of the active channel |
| dec_i | input | 1 | Word count decrements this cycle |
| autoinit_i | input | NCH | Auto-initialise enable per channel |
| eop_in_n | input | 1 | Pin level read back, active low |
| eop_oe | output | 1 | Pull the pin low when high |
| eop_out | output | 1 | Pin output value, always low |
| term_o | output | 1 | One-cycle termination action pulse |
| sreq_clr_o | output | NCH | Clear software request, per channel |
| tc_set_o | output | NCH | Set terminal-count status, per channel |
| mask_set_o | output | NCH | Set mask bit, per channel |

## Verification
The two terminations can meet on one edge. This happens when an external request is already latched and the count of the active channel rolls over during the S2 state that would apply it. The bench sets this up by pulling the line low early in a transfer. It then waits until the request is latched and presents a decrement with a zero count during the following S2. It judges the result by a single one-cycle action pulse with exactly one channel bit set, and by the absence of any action at the next S2. The next S2 must stay quiet because the request has been consumed and the block's own drive must not re-arm the latch.

// File: rtl/dma_eop_pkg.sv
package dma_eop_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_S0   = 3'd1,
      ST_S1   = 3'd2,
      ST_S2   = 3'd3,
      ST_S3   = 3'd4,
      ST_S4   = 3'd5
   } seq_state_e;

   localparam int ST_W = 3;

   function automatic logic is_active(input logic [ST_W-1:0] s);
      return (s != ST_IDLE);
   endfunction

endpackage

// File: rtl/eop_sync_edge.sv
module eop_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din_n,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("eop_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   for (genvar k = 0; k < STAGES; k++) begin : g_chain
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[k] <= 1'b1;
            else        chain_q[k] <= din_n;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[k] <= 1'b1;
            else        chain_q[k] <= chain_q[k-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign fall_o = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/eop_tc_drive.sv
module eop_tc_drive
   import dma_eop_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int HIST_N = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ST_W-1:0]  st_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             dec_i,
   output logic             tc_hit_o,
   output logic             oe_o,
   output logic             own_mask_o
);
   if (CNT_W < 1) begin : g_bad_cnt
      $error("eop_tc_drive: CNT_W must be positive");
   end

   logic              oe_q;
   logic [HIST_N-1:0] hist_q;

   assign tc_hit_o = is_active(st_i) && dec_i && (cnt_i == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       oe_q <= 1'b0;
      else if (tc_hit_o)                oe_q <= 1'b1;
      else if (st_i == ST_S4 || st_i == ST_IDLE) oe_q <= 1'b0;
   end

   for (genvar k = 0; k < HIST_N; k++) begin : g_hist
      if (k == 0) begin : g_h0
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hist_q[k] <= 1'b0;
            else        hist_q[k] <= oe_q;
         end
      end else begin : g_hn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hist_q[k] <= 1'b0;
            else        hist_q[k] <= hist_q[k-1];
         end
      end
   end

   assign oe_o       = oe_q;
   assign own_mask_o = oe_q | (|hist_q);

endmodule

// File: rtl/eop_req_latch.sv
module eop_req_latch
   import dma_eop_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [ST_W-1:0] st_i,
   input  logic            fall_i,
   input  logic            own_mask_i,
   output logic            pend_o,
   output logic            fire_o
);
   logic pend_q;
   logic set_req;

   assign set_req = is_active(st_i) && fall_i && !own_mask_i;
   assign fire_o  = (st_i == ST_S2) && pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pend_q <= 1'b0;
      else if (st_i == ST_IDLE)  pend_q <= 1'b0;
      else if (fire_o)           pend_q <= 1'b0;
      else if (set_req)          pend_q <= 1'b1;
   end

   assign pend_o = pend_q;

endmodule

// File: rtl/eop_chan_update.sv
module eop_chan_update #(
   parameter int NCH  = 4,
   parameter int CH_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fire_i,
   input  logic [CH_W-1:0] ch_i,
   input  logic [NCH-1:0]  autoinit_i,
   output logic            term_o,
   output logic [NCH-1:0]  sreq_clr_o,
   output logic [NCH-1:0]  tc_set_o,
   output logic [NCH-1:0]  mask_set_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) term_o <= 1'b0;
      else        term_o <= fire_i;
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic hit;
      assign hit = fire_i && (ch_i == CH_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sreq_clr_o[i] <= 1'b0;
            tc_set_o[i]   <= 1'b0;
            mask_set_o[i] <= 1'b0;
         end else begin
            sreq_clr_o[i] <= hit;
            tc_set_o[i]   <= hit;
            mask_set_o[i] <= hit && !autoinit_i[i];
         end
      end
   end

endmodule

// File: rtl/dma_eop_ctrl.sv
module dma_eop_ctrl
   import dma_eop_pkg::*;
#(
   parameter int NCH         = 4,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   localparam int CH_W       = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       st_i,
   input  logic [CH_W-1:0]  act_ch_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             dec_i,
   input  logic [NCH-1:0]   autoinit_i,
   input  logic             eop_in_n,
   output logic             eop_oe,
   output logic             eop_out,
   output logic             term_o,
   output logic [NCH-1:0]   sreq_clr_o,
   output logic [NCH-1:0]   tc_set_o,
   output logic [NCH-1:0]   mask_set_o
);
   localparam int HIST_N = SYNC_STAGES + 1;

   if (NCH < 1) begin : g_bad_nch
      $error("dma_eop_ctrl: NCH must be positive");
   end

   logic fall;
   logic tc_hit;
   logic own_mask;
   logic pend;
   logic fire_ext;
   logic fire;

   eop_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .din_n  (eop_in_n),
      .fall_o (fall)
   );

   eop_tc_drive #(.CNT_W(CNT_W), .HIST_N(HIST_N)) u_drive (
      .clk        (clk),
      .rst_n      (rst_n),
      .st_i       (st_i),
      .cnt_i      (cnt_i),
      .dec_i      (dec_i),
      .tc_hit_o   (tc_hit),
      .oe_o       (eop_oe),
      .own_mask_o (own_mask)
   );

   eop_req_latch u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .st_i       (st_i),
      .fall_i     (fall),
      .own_mask_i (own_mask),
      .pend_o     (pend),
      .fire_o     (fire_ext)
   );

   assign fire = fire_ext | tc_hit;

   eop_chan_update #(.NCH(NCH), .CH_W(CH_W)) u_upd (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire_i     (fire),
      .ch_i       (act_ch_i),
      .autoinit_i (autoinit_i),
      .term_o     (term_o),
      .sreq_clr_o (sreq_clr_o),
      .tc_set_o   (tc_set_o),
      .mask_set_o (mask_set_o)
   );

   assign eop_out = 1'b0;

endmodule

// File: rtl/dma_eop_ctrl_chk.sv
module dma_eop_ctrl_chk #(
   parameter int NCH   = 4,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       st_i,
   input logic [CNT_W-1:0] cnt_i,
   input logic             dec_i,
   input logic             pend,
   input logic             eop_oe,
   input logic             term_o,
   input logic [NCH-1:0]   tc_set_o,
   input logic [NCH-1:0]   sreq_clr_o,
   input logic [NCH-1:0]   mask_set_o
);
   logic rollover;
   assign rollover = (st_i != 3'd0) && dec_i && (cnt_i == '0);

   a_r2_idle_no_action: assert property (@(posedge clk) disable iff (!rst_n)
      (st_i == 3'd0) |=> !term_o);

   a_r3_apply_at_s2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_i == 3'd3 && pend) |=> (term_o && !pend));

   a_r4_idle_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (st_i == 3'd0) |=> !pend);

   a_r5_rollover_drive: assert property (@(posedge clk) disable iff (!rst_n)
      rollover |=> (term_o && eop_oe));

   a_r5_release_after_s4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_i == 3'd5 && !rollover) |=> !eop_oe);

   a_r7_single_channel: assert property (@(posedge clk) disable iff (!rst_n)
      term_o |-> ($countones(tc_set_o) == 1 && sreq_clr_o == tc_set_o));

   a_r7_quiet_without_term: assert property (@(posedge clk) disable iff (!rst_n)
      !term_o |-> (tc_set_o == '0 && sreq_clr_o == '0 && mask_set_o == '0));

   a_r7_mask_subset: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_set_o & ~tc_set_o) == '0);

   a_r8_onehot_update: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tc_set_o));

endmodule

bind dma_eop_ctrl dma_eop_ctrl_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .st_i       (st_i),
   .cnt_i      (cnt_i),
   .dec_i      (dec_i),
   .pend       (pend),
   .eop_oe     (eop_oe),
   .term_o     (term_o),
   .tc_set_o   (tc_set_o),
   .sreq_clr_o (sreq_clr_o),
   .mask_set_o (mask_set_o)
);

// File: tb/dma_eop_ctrl_tb.sv
module dma_eop_ctrl_tb;
   localparam int NCH   = 4;
   localparam int CNT_W = 16;
   localparam int CH_W  = 2;

   localparam logic [2:0] IDLE = 3'd0, S0 = 3'd1, S1 = 3'd2, S2 = 3'd3, S3 = 3'd4, S4 = 3'd5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [2:0]       st_i = IDLE;
   logic [CH_W-1:0]  act_ch_i = '0;
   logic [CNT_W-1:0] cnt_i = 16'd5;
   logic             dec_i = 1'b0;
   logic [NCH-1:0]   autoinit_i = '0;
   logic             ext_n = 1'b1;
   logic             eop_in_n;
   logic             eop_oe, eop_out, term_o;
   logic [NCH-1:0]   sreq_clr_o, tc_set_o, mask_set_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   assign eop_in_n = ext_n & ~eop_oe;

   dma_eop_ctrl #(.NCH(NCH), .CNT_W(CNT_W), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .st_i(st_i), .act_ch_i(act_ch_i), .cnt_i(cnt_i),
      .dec_i(dec_i), .autoinit_i(autoinit_i), .eop_in_n(eop_in_n),
      .eop_oe(eop_oe), .eop_out(eop_out), .term_o(term_o),
      .sreq_clr_o(sreq_clr_o), .tc_set_o(tc_set_o), .mask_set_o(mask_set_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // present state s for one clock edge; returns at the following falling edge
   task automatic tick(input logic [2:0] s);
      st_i = s;
      @(negedge clk);
      dec_i = 1'b0;
   endtask

   task automatic idle_gap(input int n);
      for (int i = 0; i < n; i++) tick(IDLE);
   endtask

   task automatic t_reset;
      chk("R1 oe", eop_oe, 0);
      chk("R1 term", term_o, 0);
      chk("R1 chan", {sreq_clr_o, tc_set_o, mask_set_o}, 0);
      chk("R9 out", eop_out, 0);
   endtask

   task automatic t_idle_pulse;
      int seen = 0;
      ext_n = 1'b0; tick(IDLE); tick(IDLE);
      ext_n = 1'b1; idle_gap(4);
      tick(S0); tick(S1); seen += term_o;
      tick(S2); seen += term_o;
      tick(S3); tick(S4); tick(S1); tick(S2); seen += term_o;
      tick(IDLE);
      chk("R2 idle pulse ignored", seen, 0);
   endtask

   task automatic t_active_pulse;
      act_ch_i = 2'd3; autoinit_i = 4'b0000;
      tick(S0);
      ext_n = 1'b0;
      tick(S1);
      tick(S2); chk("R3 not yet latched at first S2", term_o, 0);
      ext_n = 1'b1;
      tick(S3); tick(S4); tick(S1);
      chk("R3 no action before S2", term_o, 0);
      tick(S2);
      chk("R3 action after S2", term_o, 1);
      chk("R7 tc_set ch3", tc_set_o, 4'b1000);
      chk("R7 sreq_clr ch3", sreq_clr_o, 4'b1000);
      chk("R7 mask ch3", mask_set_o, 4'b1000);
      chk("R9 out during action", eop_out, 0);
      tick(S3); chk("R3 one-cycle pulse", term_o, 0);
      tick(S4); tick(S1); tick(S2);
      chk("R3 request consumed", term_o, 0);
      tick(IDLE);
   endtask

   task automatic t_discard;
      int seen = 0;
      tick(S0);
      ext_n = 1'b0;
      tick(S1); tick(S2); seen += term_o;
      ext_n = 1'b1;
      tick(S3); tick(S4);
      tick(IDLE); tick(IDLE);
      tick(S0); tick(S1); tick(S2); seen += term_o;
      tick(S3); tick(S4); tick(S1); tick(S2); seen += term_o;
      tick(IDLE);
      chk("R4 dropped on idle", seen, 0);
   endtask

   task automatic t_rollover;
      act_ch_i = 2'd2; autoinit_i = 4'b0000;
      tick(S0); tick(S1);
      cnt_i = 16'd1; dec_i = 1'b1; tick(S2);
      chk("R5 nonzero count no action", term_o, 0);
      chk("R5 nonzero count no drive", eop_oe, 0);
      tick(S3); tick(S4); tick(S1);
      cnt_i = 16'd0; dec_i = 1'b1; tick(S2);
      cnt_i = 16'hFFFF;
      chk("R5 term on rollover", term_o, 1);
      chk("R5 drive on rollover", eop_oe, 1);
      chk("R7 tc_set ch2", tc_set_o, 4'b0100);
      chk("R7 mask ch2", mask_set_o, 4'b0100);
      tick(S3);
      chk("R5 drive held", eop_oe, 1);
      chk("R9 out while driving", eop_out, 0);
      tick(S4);
      chk("R5 release after S4", eop_oe, 0);
      tick(S1); tick(S2);
      chk("R6 own drive not latched", term_o, 0);
      tick(S3); tick(S4); tick(S1); tick(S2);
      chk("R6 still quiet", term_o, 0);
      tick(IDLE);
   endtask

   task automatic t_autoinit;
      act_ch_i = 2'd1; autoinit_i = 4'b0010;
      tick(S0); tick(S1);
      cnt_i = 16'd0; dec_i = 1'b1; tick(S2);
      cnt_i = 16'hFFFF;
      chk("R7 tc_set ch1", tc_set_o, 4'b0010);
      chk("R7 no mask with autoinit", mask_set_o, 4'b0000);
      tick(S3); tick(S4); tick(IDLE); idle_gap(3);
   endtask

   task automatic t_collide;
      int pulses = 0;
      act_ch_i = 2'd0; autoinit_i = 4'b0000;
      tick(S0);
      ext_n = 1'b0;
      tick(S1); tick(S2);
      ext_n = 1'b1;
      tick(S3); tick(S4); tick(S1);
      cnt_i = 16'd0; dec_i = 1'b1; tick(S2);
      cnt_i = 16'hFFFF;
      chk("R8 combined action", term_o, 1);
      chk("R8 one channel", tc_set_o, 4'b0001);
      tick(S3); pulses += term_o;
      tick(S4); pulses += term_o;
      tick(S1); tick(S2); pulses += term_o;
      tick(IDLE);
      chk("R8 single pulse and consumed", pulses, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_idle_pulse;
      t_active_pulse;
      t_discard;
      t_rollover;
      t_autoinit;
      t_collide;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule